// File: doc/BRIEF.md
# 4x4 Residual Dequantize, Inverse Transform and Reconstruct

This block turns one 4x4 block of quantized transform coefficients back into pixels. Coefficients, an inverse-scale table, a weight table and the prediction samples are written one entry at a time through a small load port. Each entry is addressed by `row*4+col`. A start pulse then launches the block. It rescales every coefficient with its per-position multiplier and the signed quantizer shift. It can replace coefficient 0 with an externally supplied DC value. It runs a two-pass integer 4x4 inverse transform and adds the rounded residual to the prediction. The result is saturated to 8-bit samples.

The four reconstructed rows leave one per clock with a valid strobe and a row index, followed by a one-cycle done pulse. The block accepts a new start in the cycle after done, so blocks can be issued back to back. The quantizer shift, DC-substitute flag and DC value are sampled in the cycle the start is accepted.

Top module: `iqr4_recon`

## Requirements
- R1: While and after reset, `busy`, `row_valid` and `done` are low until a start is accepted.
- R2: The multiplier for position i is (scale[i] * weight[i]) truncated to its low 16 bits and read as a signed value. It is multiplied by the signed coefficient into a signed 32-bit product.
- R3: The product is shifted by the signed `qshift`. A positive value shifts left (wrapping in 32 bits) and a negative value shifts arithmetically right by its magnitude.
- R4: The shifted product gets a rounding right shift by 4 (add 8, then shift) and is saturated to the signed 16-bit range -32768..32767.
- R5: When `dc_sub` is high at start, dequantized coefficient 0 is replaced by `dc_val`.
- R6: Each row is transformed with e0=d0+d2, e1=d0-d2, e2=(d1>>>1)-d3, e3=d1+(d3>>>1), giving outputs e0+e3, e1+e2, e1-e2, e0-e3. The same butterfly is then applied to each column of that result. All arithmetic is 16-bit two's complement with wraparound.
- R7: Each final value v becomes (v+32)>>>6. The prediction sample is added and the sum is clamped to 0..255.
- R8: A start seen while idle is accepted at that clock edge. The rows 0,1,2,3 then appear with `row_valid` high after the 4th, 5th, 6th and 7th rising edges counted from the accepting edge as edge 1. Bits [8c+7:8c] of `row_data` carry column c.
- R9: `done` is high for exactly one cycle, in the cycle after row 3. A start held high through that cycle is accepted at the following edge.
- R10: A start while busy is ignored: the current block's rows are unchanged and no extra block follows.
- R11: Loads while busy are ignored and do not alter the block in flight. `ld_sel` selects 0 coefficient, 1 inverse scale, 2 weight, 3 prediction (low 8 bits of `ld_data`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one table entry this cycle |
| ld_sel | input | 2 | Target table: 0 coef, 1 scale, 2 weight, 3 prediction |
| ld_idx | input | 4 | Entry position, row*4+col |
| ld_data | input | 16 | Entry value |
| start | input | 1 | Begin processing the loaded block |
| qshift | input | 6 | Signed quantizer shift |
| dc_sub | input | 1 | Replace coefficient 0 with dc_val |
| dc_val | input | 16 | Signed substitute DC value |
| busy | output | 1 | Block in flight, start and loads ignored |
| row_valid | output | 1 | row_data holds a reconstructed row |
| row_idx | output | 2 | Row number of row_data |
| row_data | output | 32 | Four 8-bit samples, column c in bits [8c+7:8c] |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
A fault in the dequantizer or either transform pass shows up in the first `row_data` word, three cycles after the start edge. Whether a single sample or a whole row or column goes wrong depends on which pass is at fault. The mapping of a row or column to its output samples is fixed, so a swapped index shows at once. A wrong sequencer state shows within one to seven cycles as a missing, repeated or misnumbered row, a misplaced `done`, or a `busy` level that disagrees with the expected timeline. The reference model compares all of these on every cycle.

// File: rtl/iqr_pkg.sv
package iqr_pkg;
  localparam int BLK   = 4;   // transform size per dimension
  localparam int IDXW  = 4;   // bits to address BLK*BLK entries
  localparam int QRND  = 4;   // rounding shift after dequantization
  localparam int RSH   = 6;   // rounding shift after the second pass

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_OUT, ST_FIN
  } iqr_state_e;

  typedef enum logic [1:0] {
    LD_COEF = 2'd0, LD_SCALE = 2'd1, LD_WEIGHT = 2'd2, LD_PRED = 2'd3
  } iqr_sel_e;
endpackage

// File: rtl/iqr_store.sv
module iqr_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  output logic [DEPTH-1:0][DW-1:0]   rd
);
  logic [DEPTH-1:0][DW-1:0] mem;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd = mem;
endmodule

// File: rtl/iqr_dequant.sv
module iqr_dequant #(
  parameter int CW   = 16,
  parameter int SW   = 6,
  parameter int RND  = 4
) (
  input  logic [CW-1:0]        coef,
  input  logic [CW-1:0]        scl,
  input  logic [CW-1:0]        wgt,
  input  logic signed [SW-1:0] qsh,
  output logic [CW-1:0]        dq
);
  localparam int PW2 = 2 * CW;

  logic [PW2-1:0]        full;
  logic [CW-1:0]         mult;
  logic signed [PW2-1:0] prod;
  logic signed [PW2-1:0] shf;
  logic [SW-1:0]         nsh;
  logic signed [PW2:0]   rnd;
  logic signed [PW2:0]   red;

  always_comb begin
    full = scl * wgt;
    mult = full[CW-1:0];
    prod = $signed(coef) * $signed(mult);
    nsh  = -qsh;
    if (qsh[SW-1]) shf = prod >>> nsh;
    else           shf = prod <<< $unsigned(qsh);
    rnd = $signed({shf[PW2-1], shf}) + $signed((PW2+1)'(1 << (RND-1)));
    red = rnd >>> RND;
    if (red > $signed({{(CW+2){1'b0}}, {(CW-1){1'b1}}}))
      dq = {1'b0, {(CW-1){1'b1}}};
    else if (red < $signed({{(CW+2){1'b1}}, {(CW-1){1'b0}}}))
      dq = {1'b1, {(CW-1){1'b0}}};
    else
      dq = red[CW-1:0];
  end
endmodule

// File: rtl/iqr_bfly4.sv
module iqr_bfly4 #(
  parameter int W = 16
) (
  input  logic [3:0][W-1:0] d,
  output logic [3:0][W-1:0] y
);
  logic signed [W-1:0] x0, x1, x2, x3;
  logic signed [W-1:0] e0, e1, e2, e3;

  always_comb begin
    x0 = d[0];
    x1 = d[1];
    x2 = d[2];
    x3 = d[3];
    e0 = x0 + x2;
    e1 = x0 - x2;
    e2 = (x1 >>> 1) - x3;
    e3 = x1 + (x3 >>> 1);
    y[0] = e0 + e3;
    y[1] = e1 + e2;
    y[2] = e1 - e2;
    y[3] = e0 - e3;
  end
endmodule

// File: rtl/iqr4_recon.sv
module iqr4_recon
  import iqr_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int SW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic [1:0]           ld_sel,
  input  logic [IDXW-1:0]      ld_idx,
  input  logic [CW-1:0]        ld_data,
  input  logic                 start,
  input  logic signed [SW-1:0] qshift,
  input  logic                 dc_sub,
  input  logic [CW-1:0]        dc_val,
  output logic                 busy,
  output logic                 row_valid,
  output logic [1:0]           row_idx,
  output logic [BLK*PW-1:0]    row_data,
  output logic                 done
);
  localparam int NN   = BLK * BLK;
  localparam int NTAB = 3;
  localparam int PMAX = (1 << PW) - 1;
  localparam int RHALF = 1 << (RSH - 1);

  iqr_state_e state;
  logic [1:0] oc;
  logic       ld_ok;

  logic [NTAB-1:0][NN-1:0][CW-1:0] tab;
  logic [NN-1:0][PW-1:0]           pred;
  logic [NN-1:0][CW-1:0]           dq_c, dq_sel, deq_q, h_q, v_q;
  logic [BLK-1:0][BLK-1:0][CW-1:0] rp_in, rp_out, cp_in, cp_out;
  logic [BLK*PW-1:0]               rec_row;

  assign busy  = (state != ST_IDLE);
  assign ld_ok = ld_en && (state == ST_IDLE);

  // coefficient, scale and weight tables share one shape
  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    iqr_store #(.DW(CW), .DEPTH(NN)) u_tab (
      .clk   (clk),
      .we    (ld_ok && (ld_sel == 2'(g))),
      .waddr (ld_idx),
      .wdata (ld_data),
      .rd    (tab[g])
    );
  end

  iqr_store #(.DW(PW), .DEPTH(NN)) u_pred (
    .clk   (clk),
    .we    (ld_ok && (ld_sel == LD_PRED)),
    .waddr (ld_idx),
    .wdata (ld_data[PW-1:0]),
    .rd    (pred)
  );

  for (genvar i = 0; i < NN; i++) begin : g_dq
    iqr_dequant #(.CW(CW), .SW(SW), .RND(QRND)) u_dq (
      .coef (tab[LD_COEF][i]),
      .scl  (tab[LD_SCALE][i]),
      .wgt  (tab[LD_WEIGHT][i]),
      .qsh  (qshift),
      .dq   (dq_c[i])
    );
    if (i == 0) begin : g_dc
      assign dq_sel[i] = dc_sub ? dc_val : dq_c[i];
    end else begin : g_ac
      assign dq_sel[i] = dq_c[i];
    end
  end

  for (genvar r = 0; r < BLK; r++) begin : g_r
    for (genvar c = 0; c < BLK; c++) begin : g_c
      assign rp_in[r][c] = deq_q[r*BLK+c];
      assign cp_in[c][r] = h_q[r*BLK+c];
    end
    iqr_bfly4 #(.W(CW)) u_rowp (.d(rp_in[r]), .y(rp_out[r]));
    iqr_bfly4 #(.W(CW)) u_colp (.d(cp_in[r]), .y(cp_out[r]));
  end

  // reconstruction of the row selected by oc
  for (genvar c = 0; c < BLK; c++) begin : g_rec
    logic signed [CW:0]   ext, rs;
    logic signed [CW+1:0] sm;
    logic [CW-1:0]        rv;
    logic [PW-1:0]        pv;
    always_comb begin
      rv  = v_q[{oc, 2'(c)}];
      pv  = pred[{oc, 2'(c)}];
      ext = $signed({rv[CW-1], rv});
      rs  = (ext + $signed((CW+1)'(RHALF))) >>> RSH;
      sm  = $signed({rs[CW], rs}) + $signed({{(CW+2-PW){1'b0}}, pv});
      if (sm[CW+1])      rec_row[c*PW +: PW] = '0;
      else if (sm > PMAX) rec_row[c*PW +: PW] = PW'(PMAX);
      else               rec_row[c*PW +: PW] = sm[PW-1:0];
    end
  end

  // data pipeline registers, no reset needed
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && start) deq_q <= dq_sel;
    if (state == ST_ROW) begin
      for (int r = 0; r < BLK; r++)
        for (int c = 0; c < BLK; c++)
          h_q[r*BLK+c] <= rp_out[r][c];
    end
    if (state == ST_COL) begin
      for (int r = 0; r < BLK; r++)
        for (int c = 0; c < BLK; c++)
          v_q[r*BLK+c] <= cp_out[c][r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      oc        <= '0;
      row_valid <= 1'b0;
      row_idx   <= '0;
      row_data  <= '0;
      done      <= 1'b0;
    end else begin
      row_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_ROW;
        ST_ROW:  state <= ST_COL;
        ST_COL: begin
          state <= ST_OUT;
          oc    <= '0;
        end
        ST_OUT: begin
          row_valid <= 1'b1;
          row_idx   <= oc;
          row_data  <= rec_row;
          oc        <= oc + 2'd1;
          if (oc == 2'(BLK-1)) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iqr4_recon_chk.sv
module iqr4_recon_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       row_valid,
  input logic [1:0] row_idx,
  input logic       done
);
  p_start_take_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_first_row_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(row_valid) |-> (row_idx == 2'd0));

  p_row_next_r8: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_idx != 2'd3) |=> (row_valid && row_idx == $past(row_idx) + 2'd1));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !row_valid);

  p_done_after_r9: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_idx == 2'd3) |=> (done && !row_valid));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind iqr4_recon iqr4_recon_chk u_chk (.*);

// File: tb/sim_iqr4_recon.sv
`timescale 1ns/1ps
module sim_iqr4_recon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [3:0]  ld_idx = '0;
  logic [15:0] ld_data = '0;
  logic        start = 1'b0;
  logic signed [5:0] qshift = '0;
  logic        dc_sub = 1'b0;
  logic [15:0] dc_val = '0;
  logic        busy, row_valid, done;
  logic [1:0]  row_idx;
  logic [31:0] row_data;

  always #2.5 clk = ~clk;

  iqr4_recon u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .start(start), .qshift(qshift), .dc_sub(dc_sub),
    .dc_val(dc_val), .busy(busy), .row_valid(row_valid), .row_idx(row_idx),
    .row_data(row_data), .done(done)
  );

  int m_coef[16], m_scl[16], m_wgt[16], m_prd[16];
  logic [31:0] exp_row[4];
  int k = -1;
  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";

  function automatic void bf(input shortint a0, a1, a2, a3,
                             output shortint b0, b1, b2, b3);
    shortint e0, e1, e2, e3;
    e0 = a0 + a2;
    e1 = a0 - a2;
    e2 = (a1 >>> 1) - a3;
    e3 = a1 + (a3 >>> 1);
    b0 = e0 + e3; b1 = e1 + e2; b2 = e1 - e2; b3 = e0 - e3;
  endfunction

  // behavioural reference for one block (R2..R7)
  function automatic void build(input int qsh, input bit dsub, input int dcv);
    shortint dq[16], h[16], g[16];
    for (int i = 0; i < 16; i++) begin
      longint m, r;
      int p, q;
      m = longint'(m_scl[i]) * longint'(m_wgt[i]);
      m = m & 65535;
      if (m > 32767) m = m - 65536;
      p = int'(longint'(m_coef[i]) * m);
      if (qsh >= 0) q = p <<< qsh;
      else if (-qsh >= 31) q = (p < 0) ? -1 : 0;
      else q = p >>> (-qsh);
      r = (longint'(q) + 8) >>> 4;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      dq[i] = shortint'(r);
    end
    if (dsub) dq[0] = shortint'(dcv);
    for (int r = 0; r < 4; r++)
      bf(dq[r*4], dq[r*4+1], dq[r*4+2], dq[r*4+3], h[r*4], h[r*4+1], h[r*4+2], h[r*4+3]);
    for (int c = 0; c < 4; c++)
      bf(h[c], h[4+c], h[8+c], h[12+c], g[c], g[4+c], g[8+c], g[12+c]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int v;
        v = ((int'(g[r*4+c]) + 32) >>> 6) + m_prd[r*4+c];
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        exp_row[r][8*c +: 8] = 8'(v);
      end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  // model timeline
  always @(posedge clk) begin
    if (rst) k <= -1;
    else if ((k < 0 || k == 7) && start) begin
      k <= 0;
      build(int'(qshift), dc_sub, int'($signed(dc_val)));
    end else if (k >= 0 && k < 7) k <= k + 1;
    else k <= -1;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic ev;
      ev = (k >= 3 && k <= 6);
      chk({cur_tag, " busy"}, 32'(busy), 32'(k >= 0 && k <= 6));
      chk({cur_tag, " valid"}, 32'(row_valid), 32'(ev));
      chk({cur_tag, " done (R9)"}, 32'(done), 32'(k == 7));
      if (ev && row_valid) begin
        chk({cur_tag, " row_idx (R8)"}, 32'(row_idx), 32'(k - 3));
        chk({cur_tag, " row_data"}, row_data, exp_row[k-3]);
      end
    end
  end

  task automatic ld(input int sel, input int idx, input int val, input bit upd);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_idx = 4'(idx); ld_data = 16'(val);
    if (upd) begin
      case (sel)
        0: m_coef[idx] = int'($signed(16'(val)));
        1: m_scl[idx]  = val & 65535;
        2: m_wgt[idx]  = val & 65535;
        default: m_prd[idx] = val & 255;
      endcase
    end
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic fill(input int sel, input int lo, input int hi);
    for (int i = 0; i < 16; i++)
      ld(sel, i, int'($urandom_range(hi - lo)) + lo, 1'b1);
  endtask

  task automatic fill_const(input int sel, input int v);
    for (int i = 0; i < 16; i++) ld(sel, i, v, 1'b1);
  endtask

  // extra: 0 none, 1 start while busy, 2 loads while busy, 3 back-to-back start
  task automatic run_block(input string tag, input int qsh, input bit dsub,
                           input int dcv, input int extra);
    @(negedge clk);
    cur_tag = tag;
    qshift = 6'(qsh); dc_sub = dsub; dc_val = 16'(dcv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra == 1) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end else if (extra == 2) begin
      ld(3, 5, m_prd[5] ^ 255, 1'b0);
      ld(0, 0, 12345, 1'b0);
      ld(1, 3, 999, 1'b0);
    end else if (extra == 3) begin
      while (k != 6) @(negedge clk);
      qshift = 6'sd1; start = 1'b1;
      do @(negedge clk); while (k != 0);
      start = 1'b0;
    end
    while (k >= 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 valid in reset", 32'(row_valid), 0);
    chk("R1 done in reset", 32'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 0);

    // R6: flat multiplier, wide coefficients, wrap in the butterflies
    fill_const(1, 16); fill_const(2, 1);
    fill(0, -2000, 2000); fill(3, 0, 255);
    run_block("R6", 0, 1'b0, 0, 0);
    fill_const(1, 1); fill_const(2, 16);
    fill(0, -32768, 32767);
    run_block("R6 wrap", 0, 1'b0, 0, 0);

    // R2: large tables, product truncated to 16 bits and read as signed
    fill(1, 0, 65535); fill(2, 0, 65535); fill(0, -300, 300);
    run_block("R2", 0, 1'b0, 0, 0);
    fill(1, 200, 4000); fill(2, 1, 40);
    run_block("R2 mid", 0, 1'b0, 0, 0);

    // R3: left and right signed shifts
    fill(1, 1, 30); fill(2, 1, 20); fill(0, -500, 500);
    run_block("R3 left", 3, 1'b0, 0, 0);
    fill(1, 1000, 60000); fill(2, 1, 3);
    run_block("R3 right", -5, 1'b0, 0, 0);
    run_block("R3 right max", -32, 1'b0, 0, 0);

    // R4: saturation of the dequantized value
    fill(0, -32768, 32767); fill(1, 100, 300); fill(2, 50, 100);
    run_block("R4 sat", 8, 1'b0, 0, 0);
    fill_const(0, 32767); fill_const(1, 1); fill_const(2, 1);
    run_block("R4 round", 0, 1'b0, 0, 0);

    // R5: DC substitution
    fill(0, -100, 100); fill_const(1, 16); fill_const(2, 1);
    run_block("R5 pos", 0, 1'b1, 1000, 0);
    run_block("R5 neg", 0, 1'b1, -1000, 0);

    // R7: clamps at both ends
    fill_const(0, 0); ld(0, 0, 3000, 1'b1);
    fill_const(3, 250);
    run_block("R7 high", 0, 1'b0, 0, 0);
    ld(0, 0, -3000, 1'b1); fill_const(3, 3);
    run_block("R7 low", 0, 1'b0, 0, 0);

    // R8 / R9 / R10 / R11 sequencing
    fill(0, -800, 800); fill(3, 0, 255); fill(1, 10, 40); fill(2, 1, 4);
    run_block("R8", 1, 1'b0, 0, 0);
    run_block("R9 back-to-back", 0, 1'b0, 0, 3);
    run_block("R10 start busy", 0, 1'b0, 0, 1);
    run_block("R11 load busy", 0, 1'b1, -77, 2);
    run_block("R11 after", 2, 1'b0, 0, 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule